// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block prepares the second operand of an arithmetic unit. It shifts or rotates a data word and produces a shifter carry-out. Five operations are available: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The shift amount comes from one of two sources. The first is a 5-bit immediate field. The second is the low byte of a register value, passed in as an 8-bit amount.

The two amount sources treat zero and large amounts differently. An immediate of zero is not a shift of zero for every operation. For the right shifts it encodes a full-width shift, and for rotate it selects the one-bit rotate through carry. A register amount of zero leaves the data and the carry untouched. Register amounts of the word width or more have fixed results that the requirements list. The block holds no flags itself: the caller supplies the present carry and stores the carry-out if it needs it.

Both outputs are registered, so a result appears one clock after its inputs are presented.

Top module: `bsh_top`

## Requirements
- R1: Outputs are registered and show the result of the inputs sampled on the previous rising clock edge. While rst_n is low, data_out and carry_out are 0.
- R2: The operation code is: op 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a logical left shift by n (1 to 31), the result is data << n and the carry is input bit 32-n.
- R3: For a logical right shift, arithmetic right shift or rotate right by n (1 to 31), the result is the shifted or rotated word and the carry is input bit n-1.
- R4: With use_reg = 1 and reg_amt = 0, the data and the carry pass through unchanged for every op.
- R5: A register logical left shift by exactly 32 gives 0 with carry = input bit 0. Any amount from 33 to 255 gives 0 with carry 0.
- R6: A register logical right shift by exactly 32 gives 0 with carry = input bit 31. Any amount from 33 to 255 gives 0 with carry 0.
- R7: A register arithmetic right shift by 32 or more fills every bit with input bit 31, and the carry is input bit 31.
- R8: A register rotate uses the amount modulo 32. If the low 5 bits are 0 and the amount is nonzero, the data is unchanged and the carry is input bit 31.
- R9: An immediate rotate with imm_amt = 0 shifts right by one, puts carry_in in bit 31, and outputs the old bit 0 as the carry.
- R10: An immediate logical right or arithmetic right shift with imm_amt = 0 acts as a 32-bit shift. The result is 0 or the sign fill, and the carry is input bit 31.
- R11: An immediate logical left shift with imm_amt = 0 passes the data and carry_in through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 32 | Word to shift |
| op | input | 2 | Operation: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| use_reg | input | 1 | 1 selects reg_amt, 0 selects imm_amt |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Register-sourced shift amount (low byte) |
| carry_in | input | 1 | Present carry flag |
| data_out | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default parameters: a 32-bit word and an 8-bit register amount. With these values every register amount from 0 to 255 can be applied. That covers exactly 32, every amount above it, and the rotate multiples 64, 96, 128, 160, 192 and 224 next to nonzero low bits. Directed vectors cover each zero and oversize encoding. These are followed by several hundred random vectors, biased toward amounts around the word width.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    // Operation encoding; the values are decoded by the amount stage and the core.
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_op_e;
endpackage

// File: rtl/bsh_amount.sv
// Turns the immediate or register amount into one effective amount
// and flags the one-bit rotate-through-carry case.
module bsh_amount
    import bsh_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  sh_op_e             op,
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm_amt,
    input  logic [AMT_W-1:0]   reg_amt,
    output logic [AMT_W-1:0]   amt,
    output logic               is_rrx
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

    logic imm_zero;

    always_comb begin
        imm_zero = (imm_amt == '0);
        is_rrx   = 1'b0;
        if (use_reg) begin
            amt = reg_amt;
        end else if (imm_zero) begin
            unique case (op)
                SH_LSL:         amt = '0;
                SH_LSR, SH_ASR: amt = FULL_AMT;
                default: begin
                    amt    = '0;
                    is_rrx = 1'b1;
                end
            endcase
        end else begin
            amt = AMT_W'(imm_amt);
        end
    end

    // R9: the one-bit rotate is only reachable from the immediate source
    always_comb begin
        if (use_reg) assert (!is_rrx) else $error("p_rrx_imm_only_r9");
    end
endmodule

// File: rtl/bsh_core.sv
// Combinational shift/rotate datapath with carry-out.
module bsh_core
    import bsh_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     data,
    input  sh_op_e           op,
    input  logic [AMT_W-1:0] amt,
    input  logic             is_rrx,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam int SH_W = $clog2(W);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

    logic [W:0]            lsl_ext;
    logic [W:0]            lsr_ext;
    logic signed [W:0]     asr_src;
    logic [W:0]            asr_ext;
    logic [AMT_W-1:0]      asr_amt;
    logic [SH_W-1:0]       rot_amt;
    logic [SH_W:0]         rot_comp;
    logic [W-1:0]          rot_word;

    always_comb begin
        // Extra bit beside the word catches the last bit shifted out.
        lsl_ext  = {1'b0, data} << amt;
        lsr_ext  = {data, 1'b0} >> amt;
        asr_src  = {data, 1'b0};
        asr_amt  = (amt > FULL_AMT) ? FULL_AMT : amt;
        asr_ext  = asr_src >>> asr_amt;
        rot_amt  = amt[SH_W-1:0];
        rot_comp = (SH_W+1)'(W) - {1'b0, rot_amt};
        rot_word = (data >> rot_amt) | (data << rot_comp);

        if (is_rrx) begin
            res  = {cin, data[W-1:1]};
            cout = data[0];
        end else if (amt == '0) begin
            res  = data;
            cout = cin;
        end else begin
            unique case (op)
                SH_LSL: begin
                    res  = lsl_ext[W-1:0];
                    cout = lsl_ext[W];
                end
                SH_LSR: begin
                    res  = lsr_ext[W:1];
                    cout = lsr_ext[0];
                end
                SH_ASR: begin
                    res  = asr_ext[W:1];
                    cout = asr_ext[0];
                end
                default: begin
                    res  = rot_word;
                    cout = rot_word[W-1];
                end
            endcase
        end
    end

    // R7: an arithmetic shift never changes the sign bit
    always_comb begin
        if (!is_rrx && op == SH_ASR)
            assert (res[W-1] == data[W-1]) else $error("p_asr_sign_kept_r7");
    end
endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     data_in,
    input  logic [1:0]       op,
    input  logic             use_reg,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             carry_in,
    output logic [W-1:0]     data_out,
    output logic             carry_out
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         carry;
    } sh_out_t;

    sh_op_e           op_e;
    logic [AMT_W-1:0] eff_amt;
    logic             rrx_sel;
    logic [W-1:0]     core_res;
    logic             core_cout;
    sh_out_t          out_d;
    sh_out_t          out_q;

    assign op_e = sh_op_e'(op);

    bsh_amount #(.W(W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amount (
        .op      (op_e),
        .use_reg (use_reg),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .amt     (eff_amt),
        .is_rrx  (rrx_sel)
    );

    bsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
        .data   (data_in),
        .op     (op_e),
        .amt    (eff_amt),
        .is_rrx (rrx_sel),
        .cin    (carry_in),
        .res    (core_res),
        .cout   (core_cout)
    );

    always_comb begin
        out_d.word  = core_res;
        out_d.carry = core_cout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign data_out  = out_q.word;
    assign carry_out = out_q.carry;

    p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg && reg_amt == '0) |=>
        (data_out == $past(data_in) && carry_out == $past(carry_in)));

    p_lsl_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg && op == 2'd0 && reg_amt > AMT_W'(W)) |=>
        (data_out == '0 && !carry_out));

    p_lsr_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg && op == 2'd1 && reg_amt > AMT_W'(W)) |=>
        (data_out == '0 && !carry_out));

    p_asr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg && op == 2'd2 && reg_amt >= AMT_W'(W)) |=>
        (data_out == {W{$past(data_in[W-1])}} && carry_out == $past(data_in[W-1])));

    p_ror_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg && op == 2'd3 && reg_amt != '0 && reg_amt[$clog2(W)-1:0] == '0) |=>
        (data_out == $past(data_in) && carry_out == $past(data_in[W-1])));

    p_rrx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_reg && op == 2'd3 && imm_amt == '0) |=>
        (data_out == {$past(carry_in), $past(data_in[W-1:1])} && carry_out == $past(data_in[0])));

    p_imm_lsl0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_reg && op == 2'd0 && imm_amt == '0) |=>
        (data_out == $past(data_in) && carry_out == $past(carry_in)));
endmodule

// File: tb/bsh_top_test.sv
module bsh_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] data_in;
    logic [1:0]  op;
    logic        use_reg;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic        carry_in;
    logic [31:0] data_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bsh_top uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .op(op), .use_reg(use_reg),
        .imm_amt(imm_amt), .reg_amt(reg_amt), .carry_in(carry_in),
        .data_out(data_out), .carry_out(carry_out)
    );

    // Behavioural model: shifts one bit at a time, as many times as asked.
    function automatic logic [32:0] model(input logic [31:0] d, input logic [1:0] o,
                                          input logic ur, input logic [4:0] im,
                                          input logic [7:0] ra, input logic c);
        int n;
        logic [31:0] w = d;
        logic cy = c;
        if (ur) n = ra;
        else begin
            n = im;
            if (im == 0) begin
                if (o == 1 || o == 2) n = 32;
                if (o == 3) return {d[0], c, d[31:1]};
            end
        end
        if (n == 0) return {c, d};
        case (o)
            2'd0: for (int i = 0; i < n; i++) begin cy = w[31]; w = {w[30:0], 1'b0}; end
            2'd1: for (int i = 0; i < n; i++) begin cy = w[0]; w = {1'b0, w[31:1]}; end
            2'd2: for (int i = 0; i < n; i++) begin cy = w[0]; w = {w[31], w[31:1]}; end
            default: begin
                if (n % 32 == 0) cy = w[31];
                for (int i = 0; i < n % 32; i++) begin cy = w[0]; w = {w[0], w[31:1]}; end
            end
        endcase
        return {cy, w};
    endfunction

    task automatic apply(input logic [31:0] d, input logic [1:0] o, input logic ur,
                         input logic [4:0] im, input logic [7:0] ra, input logic c,
                         input string tag);
        logic [32:0] exp;
        @(negedge clk);
        data_in = d; op = o; use_reg = ur; imm_amt = im; reg_amt = ra; carry_in = c;
        exp = model(d, o, ur, im, ra, c);
        @(posedge clk);
        #2;
        checks++;
        if ({carry_out, data_out} !== exp) begin
            errors++;
            $display("FAIL %s: got %h carry %b, expected %h carry %b",
                     tag, data_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        data_in = 32'hFFFF_FFFF; op = 2'd0; use_reg = 1'b1; imm_amt = 5'd0;
        reg_amt = 8'd0; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (data_out !== 32'h0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got %h %b, expected 0 0", data_out, carry_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 latency: new inputs are not visible before the next rising edge
        apply(32'h1234_5678, 2'd0, 1'b0, 5'd4, 8'd0, 1'b0, "R1");
        @(negedge clk);
        data_in = 32'hF000_000F; op = 2'd1; use_reg = 1'b0; imm_amt = 5'd4;
        #1;
        checks++;
        if (data_out !== 32'h2345_6780) begin
            errors++;
            $display("FAIL R1 latency: got %h, expected 23456780", data_out);
        end

        apply(32'h8000_0001, 2'd0, 1'b0, 5'd1, 8'd0, 1'b0, "R2");
        apply(32'h4000_0000, 2'd0, 1'b1, 5'd0, 8'd2, 1'b0, "R2");
        apply(32'hDEAD_BEEF, 2'd0, 1'b0, 5'd31, 8'd0, 1'b1, "R2");
        apply(32'h8000_0010, 2'd1, 1'b0, 5'd5, 8'd0, 1'b0, "R3");
        apply(32'h8000_0010, 2'd2, 1'b1, 5'd0, 8'd4, 1'b0, "R3");
        apply(32'h0000_00F1, 2'd3, 1'b0, 5'd4, 8'd0, 1'b0, "R3");
        apply(32'h8000_0000, 2'd1, 1'b1, 5'd0, 8'd31, 1'b0, "R3");
        for (int k = 0; k < 4; k++) begin
            apply(32'hA5A5_5A5A, 2'(k), 1'b1, 5'd7, 8'd0, 1'b1, "R4");
            apply(32'h5A5A_A5A5, 2'(k), 1'b1, 5'd0, 8'd0, 1'b0, "R4");
        end
        apply(32'h0000_0001, 2'd0, 1'b1, 5'd0, 8'd32, 1'b0, "R5");
        apply(32'hFFFF_FFFE, 2'd0, 1'b1, 5'd0, 8'd32, 1'b1, "R5");
        apply(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd33, 1'b1, "R5");
        apply(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd255, 1'b1, "R5");
        apply(32'h8000_0000, 2'd1, 1'b1, 5'd0, 8'd32, 1'b0, "R6");
        apply(32'h7FFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd32, 1'b1, "R6");
        apply(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd33, 1'b1, "R6");
        apply(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd200, 1'b1, "R6");
        apply(32'h8000_0000, 2'd2, 1'b1, 5'd0, 8'd32, 1'b0, "R7");
        apply(32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 8'd100, 1'b1, "R7");
        apply(32'h9000_0000, 2'd2, 1'b1, 5'd0, 8'd255, 1'b0, "R7");
        apply(32'h8000_0001, 2'd3, 1'b1, 5'd0, 8'd32, 1'b0, "R8");
        apply(32'h7000_0001, 2'd3, 1'b1, 5'd0, 8'd64, 1'b1, "R8");
        apply(32'h0000_00F0, 2'd3, 1'b1, 5'd0, 8'd36, 1'b0, "R8");
        apply(32'h1234_5678, 2'd3, 1'b1, 5'd0, 8'd232, 1'b0, "R8");
        apply(32'h0000_0003, 2'd3, 1'b0, 5'd0, 8'd9, 1'b0, "R9");
        apply(32'h8000_0002, 2'd3, 1'b0, 5'd0, 8'd9, 1'b1, "R9");
        apply(32'h8000_0001, 2'd1, 1'b0, 5'd0, 8'd0, 1'b0, "R10");
        apply(32'h8000_0001, 2'd2, 1'b0, 5'd0, 8'd0, 1'b0, "R10");
        apply(32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0, 8'd0, 1'b1, "R10");
        apply(32'hCAFE_F00D, 2'd0, 1'b0, 5'd0, 8'd40, 1'b1, "R11");
        apply(32'hCAFE_F00D, 2'd0, 1'b0, 5'd0, 8'd40, 1'b0, "R11");

        // Mixed random vectors, amounts biased around the word width (R2 R3 R5 R6 R7 R8)
        for (int k = 0; k < 600; k++) begin
            logic [7:0] ra;
            ra = (k % 3 == 0) ? 8'(28 + $urandom_range(0, 8)) : 8'($urandom);
            apply($urandom, 2'($urandom), 1'($urandom), 5'($urandom), ra,
                  1'($urandom), "random R2 R3 R5 R6 R7 R8");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule